// File: doc/BRIEF.md
# Stream Pipeline Register Slice

This block sits on a valid/ready stream and adds one pipeline stage to it. The stage type is fixed at compile time. The chosen type decides which of the three stream signals get a register in their path. The payload width is a parameter. Input and output use the same handshake: a beat moves across a port only in a cycle where valid and ready are both high.

There are four stage types:

- **Forward:** registers valid and payload. It costs one cycle of latency.
- **Backward:** leaves the data path combinational. It cuts the ready path with a one-entry skid register and a per-bit select.
- **Full:** places a backward stage in front of a forward stage. No combinational path remains between the input side and the output side.
- **Half:** uses one register for valid and one for payload, and derives ready from the stored valid flag. This is cheap, but the stage moves at most one beat every two cycles.

In every type, beats come out in the order they went in, with none lost and none repeated, whatever pattern of backpressure the consumer applies.

Top module: `stream_reg_slice`

## Requirements
- R1: A beat is accepted at the input only when inValid and inReady are both high at a rising clock edge, and delivered only when outValid and outReady are both high. The delivered beats equal the accepted beats in the same order, with none lost or repeated.
- R2: In forward mode (MODE = SLICE_FWD, value 0), a beat accepted while the stage holds nothing appears on outValid/outData one cycle later. Output valid and payload are driven only from registers.
- R3: In forward mode, inReady equals (not outValid) or outReady, in every cycle.
- R4: In backward mode (MODE = SLICE_BWD, value 1), when the skid register is empty, outValid follows inValid in the same cycle and outData equals inData. There is zero latency.
- R5: In backward mode, an accepted beat that cannot leave because outReady is low is kept in the skid register. inReady is low exactly while that register holds a beat.
- R6: In full mode (MODE = SLICE_FULL, value 2), inReady does not depend on outReady within a cycle. A beat accepted while the stage is empty appears at the output one cycle later.
- R7: In half mode (MODE = SLICE_HALF, value 3), inReady does not depend on outReady within a cycle. A beat accepted while empty appears one cycle later. inReady is low in the cycle after any accepted beat, so at most one beat passes every two cycles.
- R8: While outValid is high and outReady is low, outValid stays high and outData stays unchanged in the next cycle.
- R9: While reset is asserted, every stored valid flag is clear. outValid is low when inValid is low, and inReady is high.
- R10: With a source and a consumer that are always ready, forward, backward and full modes pass one beat per cycle, and half mode passes one beat per two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Upstream beat present |
| inReady | output | 1 | Stage can take the upstream beat |
| inData | input | DATA_W | Upstream payload |
| outValid | output | 1 | Downstream beat present |
| outReady | input | 1 | Downstream consumer takes the beat |
| outData | output | DATA_W | Downstream payload |

## Verification
The hardest case to reach from the ports is a filled skid register in full mode. That needs a beat accepted while the forward register is both occupied and stalled, followed by a release of outReady in a cycle where the source still has a beat waiting. Sustained random backpressure at a low ready rate, following a stretch of unthrottled flow, produces these sequences repeatedly. A per-beat sequence scoreboard then shows any drop, duplicate or reorder as the skid and forward registers hand beats across. Each of the four modes runs as its own instance under the same phase schedule. In the modes that claim a registered ready, the bench flips outReady part-way through the cycle and checks that inReady does not move.

// File: rtl/stream_slice_pkg.sv
`timescale 1ns/1ps
package stream_slice_pkg;

  // Stage variant selected at compile time. Encodings are part of R2..R7.
  typedef enum logic [1:0] {
    SLICE_FWD  = 2'd0,
    SLICE_BWD  = 2'd1,
    SLICE_FULL = 2'd2,
    SLICE_HALF = 2'd3
  } sliceMode_e;

  // Strobes from the control half to the payload half.
  typedef struct packed {
    logic skidLoad;  // capture the incoming payload into the skid register
    logic skidSel;   // present the skid register instead of the input payload
    logic holdLoad;  // capture the selected payload into the output register
  } sliceStrobes_t;

endpackage

// File: rtl/slice_ctrl.sv
`timescale 1ns/1ps
module slice_ctrl
  import stream_slice_pkg::*;
#(
  parameter sliceMode_e MODE = SLICE_FULL
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output sliceStrobes_t strobes
);

  localparam bit HAS_SKID = (MODE == SLICE_BWD) || (MODE == SLICE_FULL);
  localparam bit HAS_FWD  = (MODE == SLICE_FWD) || (MODE == SLICE_FULL);
  localparam bit HAS_HALF = (MODE == SLICE_HALF);
  localparam bit HAS_HOLD = HAS_FWD || HAS_HALF;

  logic skidFull;   // skid register occupied
  logic holdFull;   // output register occupied
  logic midValid;   // valid between the ready-cut part and the output part
  logic midReady;   // ready between the ready-cut part and the output part
  logic skidLoad;
  logic holdLoad;

  // Ready-cut part: one-entry skid buffer
  generate
    if (HAS_SKID) begin : g_skid
      assign midValid = inValid || skidFull;
      assign skidLoad = inValid && !skidFull && !midReady;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          skidFull <= 1'b0;
        end else if (skidLoad) begin
          skidFull <= 1'b1;
        end else if (midReady) begin
          skidFull <= 1'b0;
        end
      end
    end else begin : g_noSkid
      assign midValid = inValid;
      assign skidLoad = 1'b0;
      assign skidFull = 1'b0;
    end
  endgenerate

  // Output part: full-rate register, half-rate register, or a plain wire
  generate
    if (HAS_FWD) begin : g_fwd
      assign midReady = !holdFull || outReady;
      assign holdLoad = midValid && midReady;
    end else if (HAS_HALF) begin : g_half
      // Ready comes only from the stored flag, never from outReady.
      assign midReady = !holdFull;
      assign holdLoad = midValid && !holdFull;
    end else begin : g_pass
      assign midReady = outReady;
      assign holdLoad = 1'b0;
    end
  endgenerate

  generate
    if (HAS_HOLD) begin : g_holdFlag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          holdFull <= 1'b0;
        end else if (holdLoad) begin
          holdFull <= 1'b1;
        end else if (outReady) begin
          holdFull <= 1'b0;
        end
      end
      assign outValid = holdFull;
    end else begin : g_noHoldFlag
      assign holdFull = 1'b0;
      assign outValid = midValid;
    end
  endgenerate

  generate
    if (HAS_SKID) begin : g_readySkid
      assign inReady = !skidFull;
    end else begin : g_readyMid
      assign inReady = midReady;
    end
  endgenerate

  assign strobes.skidLoad = skidLoad;
  assign strobes.skidSel  = skidFull;
  assign strobes.holdLoad = holdLoad;

endmodule

// File: rtl/slice_data.sv
`timescale 1ns/1ps
module slice_data
  import stream_slice_pkg::*;
#(
  parameter sliceMode_e MODE   = SLICE_FULL,
  parameter int         DATA_W = 16
) (
  input  logic              clk,
  input  sliceStrobes_t     strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);

  localparam bit HAS_SKID = (MODE == SLICE_BWD) || (MODE == SLICE_FULL);
  localparam bit HAS_HOLD = (MODE != SLICE_BWD);

  logic [DATA_W-1:0] skidData;
  logic [DATA_W-1:0] midData;
  logic [DATA_W-1:0] holdData;

  generate
    if (HAS_SKID) begin : g_skid
      always_ff @(posedge clk) begin
        if (strobes.skidLoad) begin
          skidData <= inData;
        end
      end
      // one 2:1 select per payload bit
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign midData[b] = strobes.skidSel ? skidData[b] : inData[b];
      end
    end else begin : g_noSkid
      logic unusedSkid;
      assign skidData   = '0;
      assign midData    = inData;
      assign unusedSkid = strobes.skidLoad ^ strobes.skidSel ^ (^skidData);
    end
  endgenerate

  generate
    if (HAS_HOLD) begin : g_hold
      always_ff @(posedge clk) begin
        if (strobes.holdLoad) begin
          holdData <= midData;
        end
      end
      assign outData = holdData;
    end else begin : g_noHold
      logic unusedHold;
      assign holdData   = '0;
      assign outData    = midData;
      assign unusedHold = strobes.holdLoad ^ (^holdData);
    end
  endgenerate

endmodule

// File: rtl/stream_reg_slice.sv
`timescale 1ns/1ps
module stream_reg_slice
  import stream_slice_pkg::*;
#(
  parameter sliceMode_e MODE   = SLICE_FULL,
  parameter int         DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  sliceStrobes_t strobes;

  slice_ctrl #(
    .MODE(MODE)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .outValid(outValid),
    .outReady(outReady),
    .strobes (strobes)
  );

  slice_data #(
    .MODE  (MODE),
    .DATA_W(DATA_W)
  ) u_data (
    .clk    (clk),
    .strobes(strobes),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: rtl/slice_checker.sv
`timescale 1ns/1ps
module slice_checker
  import stream_slice_pkg::*;
#(
  parameter sliceMode_e MODE   = SLICE_FULL,
  parameter int         DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [DATA_W-1:0] inData,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData
);

  // R8: a stalled output keeps its beat
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  generate
    if (MODE != SLICE_BWD) begin : g_lat
      // R2 / R6 / R7: an accepted beat leaves the stage occupied one cycle later
      p_accept_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
        inValid && inReady |=> outValid);
    end
    if (MODE == SLICE_FWD) begin : g_fwd
      // R3: ready low only when a beat is held and not being taken
      p_fwd_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
        !inReady |-> outValid && !outReady);
    end
    if (MODE == SLICE_BWD) begin : g_bwd
      // R4: empty skid means the input payload passes straight through
      p_bwd_pass_r4: assert property (@(posedge clk) disable iff (!rstN)
        inValid && inReady |-> outValid && (outData == inData));
      // R5: a full skid always offers its beat downstream
      p_skid_offer_r5: assert property (@(posedge clk) disable iff (!rstN)
        !inReady |-> outValid);
    end
    if (MODE == SLICE_HALF) begin : g_half
      // R7: no two consecutive accepted beats
      p_half_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
        inValid && inReady |=> !inReady);
    end
  endgenerate

endmodule

bind stream_reg_slice slice_checker #(.MODE(MODE), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/stream_reg_slice_tb.sv
`timescale 1ns/100ps
module stream_reg_slice_tb;
  import stream_slice_pkg::*;

  localparam int DW     = 16;
  localparam int NLANES = 4;
  localparam int NCYC   = 540;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  int checkCnt = 0;
  int failCnt = 0;
  logic [NLANES-1:0] laneDone = '0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [DW-1:0] expData(input int lane, input int seq);
    logic [31:0] v;
    v = (seq * 40503) ^ (lane << 13) ^ (seq >> 3);
    return v[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
  end

  for (genvar k = 0; k < NLANES; k++) begin : g_lane
    localparam sliceMode_e LM = sliceMode_e'(k);
    logic          inValid, inReady, outValid, outReady;
    logic [DW-1:0] inData, outData;

    stream_reg_slice #(.MODE(LM), .DATA_W(DW)) u_dut (
      .clk(clk), .rstN(rstN),
      .inValid(inValid), .inReady(inReady), .inData(inData),
      .outValid(outValid), .outReady(outReady), .outData(outData)
    );

    initial begin
      int sent = 0, rcv = 0, firedSeq = 0, flowFires = 0;
      int vPct, rPct;
      bit inFire = 0, outFire = 0, prevInFire = 0, prevEmpty = 0, prevStall = 0;
      logic [DW-1:0] prevData = '0;
      logic rSnap;
      inValid = 1'b0; inData = '0; outReady = 1'b0;
      @(negedge clk); @(negedge clk); #1;
      // R9: reset state
      check(inReady === 1'b1 && outValid === 1'b0, "R9", "reset ready/valid",
            {inReady, outValid}, 2'b10);
      wait (rstN);
      for (int cyc = 0; cyc < NCYC; cyc++) begin
        @(negedge clk);
        if (cyc < 200)      begin vPct = 60;  rPct = 50;  end
        else if (cyc < 300) begin vPct = 100; rPct = 100; end
        else if (cyc < 420) begin vPct = 80;  rPct = 20;  end
        else if (cyc < 500) begin vPct = 50;  rPct = 70;  end
        else                begin vPct = 0;   rPct = 100; end
        if (!inValid || inFire) begin
          inValid = ($urandom_range(99, 0) < vPct);
          inData  = expData(k, sent);
        end
        outReady = ($urandom_range(99, 0) < rPct);
        #1;
        if (LM == SLICE_FULL || LM == SLICE_HALF) begin
          rSnap = inReady;
          outReady = !outReady;
          #1;
          check(inReady === rSnap, (LM == SLICE_FULL) ? "R6" : "R7",
                "inReady moved with outReady", inReady, rSnap);
          outReady = !outReady;
          #1;
        end else begin
          #2;
        end
        // sample point, 1 ns before the rising edge
        inFire  = inValid && inReady;
        outFire = outValid && outReady;
        if (prevStall)
          check(outValid === 1'b1 && outData === prevData, "R8", "stalled beat changed",
                {outValid, outData}, {1'b1, prevData});
        if (LM != SLICE_BWD && prevInFire && prevEmpty)
          check(outValid === 1'b1 && outData === expData(k, firedSeq),
                (LM == SLICE_FWD) ? "R2" : (LM == SLICE_FULL) ? "R6" : "R7",
                "one-cycle latency", {outValid, outData}, {1'b1, expData(k, firedSeq)});
        if (LM == SLICE_FWD)
          check(inReady === (!outValid || outReady), "R3", "forward ready",
                inReady, !outValid || outReady);
        if (LM == SLICE_BWD) begin
          check(inReady === (sent == rcv), "R5", "ready vs skid occupancy",
                inReady, sent == rcv);
          if (inValid && sent == rcv)
            check(outValid === 1'b1 && outData === inData, "R4", "pass-through",
                  {outValid, outData}, {1'b1, inData});
        end
        if (LM == SLICE_HALF && prevInFire)
          check(inReady === 1'b0, "R7", "ready after accept", inReady, 0);
        prevEmpty = (sent == rcv);
        if (inFire) begin
          firedSeq = sent;
          sent++;
        end
        if (outFire) begin
          check(outData === expData(k, rcv), "R1", "beat order/content",
                outData, expData(k, rcv));
          rcv++;
          if (cyc >= 210 && cyc < 290) flowFires++;
        end
        prevInFire = inFire;
        prevStall  = outValid && !outReady;
        prevData   = outData;
      end
      // R1: nothing lost or repeated once drained
      check(sent == rcv && sent > 100, "R1", "drained count", rcv, sent);
      // R10: throughput under unthrottled flow (80 sampled cycles)
      if (LM == SLICE_HALF)
        check(flowFires >= 39 && flowFires <= 41, "R10", "half-rate beats", flowFires, 40);
      else
        check(flowFires == 80, "R10", "full-rate beats", flowFires, 80);
      laneDone[k] = 1'b1;
    end
  end

  initial begin
    wait (&laneDone);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule